// File: doc/BRIEF.md
# Clock Ratio Auto-Detector

This block works out, at run time, the integer ratio between a fast processor clock and a slower memory-side clock that is derived from it and stays in phase with it. It supports ratios from 1:1 to 8:1. A memory controller uses the result as its count of wait states. A toggle flop in the slow domain is carried into the fast domain through a two-flop synchronizer. Each change of the synchronized toggle marks one slow-clock cycle, and the block counts the fast cycles between two such marks.

A measurement is accepted only when two consecutive slow cycles give the same in-range count. The block then raises its valid flag. Until that happens, it reports the most conservative wait-state value, which is the one for 8:1. The output field is 4 bits wide and shares its encoding with the field that software would otherwise program. When detection is off, the programmed field passes through unchanged. When detection is on, the output carries the detected wait-state count, which is the ratio minus one.

Top module: `clk_ratio_detect`

## Requirements
- R1: While `detect_en` is 0, `ratio_out` equals `manual_ratio` bit for bit, including values above 7.
- R2: While `detect_en` is 0, `ratio_valid` is 0, and it is 0 from the first fast edge after `detect_en` is sampled low.
- R3: While `detect_en` is 1 and `ratio_valid` is 0, `ratio_out` is 7, the wait-state value for 8:1.
- R4: While `ratio_valid` is 1, `ratio_out` equals the detected ratio minus one, so 1:1 gives 0. `manual_ratio` has no effect on it.
- R5: The first slow-cycle mark after enable only starts the count. `ratio_valid` rises only on the fast edge of a mark whose count equals the count of the slow cycle just before it. It therefore stays 0 for at least 2N-1 fast edges after enable at ratio N.
- R6: Every ratio from 1:1 to 8:1 is detected and reported.
- R7: A running count above 8, caused by a slow clock slower than 8:1 or by a stalled slow clock, clears `ratio_valid` on the next fast edge. A measured count of 0 or above 8 is never accepted.
- R8: When the ratio changes while the block is locked, the first differing count clears `ratio_valid`. The block locks again on the new ratio after two equal counts.
- R9: While reset is asserted, `ratio_valid` is 0 and the detector holds no lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast processor clock |
| clk_slow | input | 1 | Memory-side clock, an integer division of clk_fast |
| rst_n | input | 1 | Asynchronous active-low reset |
| detect_en | input | 1 | 1 selects the detected ratio, 0 selects the manual field |
| manual_ratio | input | 4 | Programmed wait-state field |
| ratio_out | output | 4 | Wait-state value in effect |
| ratio_valid | output | 1 | Detected value is locked |

## Verification
A slow-cycle measurement strobe and the clearing caused by dropping `detect_en` can land on the same fast edge. The clear must win, and the strobe must not rebuild any lock state. The bench provokes this at 1:1, where every fast edge carries a strobe, by lowering `detect_en` while the block is locked. It judges the result by checking three things: `ratio_valid` falls, `ratio_out` shows the manual field at once, and after re-enabling, `ratio_valid` stays low until a fresh pair of matching counts has been seen.

// File: rtl/crd_pkg.sv
package crd_pkg;
  parameter int MAX_RATIO = 8;
  parameter int FIELD_W   = 4;
  parameter int CNT_W     = 4;
  localparam int SAFE_WS  = MAX_RATIO - 1;
  localparam int CNT_SAT  = (1 << CNT_W) - 1;
endpackage

// File: rtl/crd_edge_sync.sv
module crd_edge_sync (
  input  logic clk_fast,
  input  logic clk_slow,
  input  logic rst_n,
  input  logic rst_sync_n,
  output logic slow_evt
);
  logic tog_q;
  logic tog_d;
  logic s1_q, s2_q, s3_q;

  always_comb tog_d = ~tog_q;

  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_d;
  end

  always_ff @(posedge clk_fast or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= tog_q;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_comb slow_evt = s2_q ^ s3_q;
endmodule

// File: rtl/crd_period_counter.sv
module crd_period_counter
  import crd_pkg::*;
#(
  parameter int MAXR = MAX_RATIO,
  parameter int CW   = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          slow_evt,
  output logic          meas_stb,
  output logic [CW-1:0] meas_cnt,
  output logic          overrun
);
  localparam logic [CW-1:0] SAT = {CW{1'b1}};

  logic          primed_q, primed_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    primed_d = primed_q;
    cnt_d    = cnt_q;
    if (clr) begin
      primed_d = 1'b0;
      cnt_d    = '0;
    end else if (slow_evt) begin
      primed_d = 1'b1;
      cnt_d    = CW'(1);
    end else if (primed_q && cnt_q != SAT) begin
      cnt_d    = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      primed_q <= primed_d;
      cnt_q    <= cnt_d;
    end
  end

  always_comb begin
    meas_stb = slow_evt && primed_q && !clr;
    meas_cnt = cnt_q;
    overrun  = primed_q && !clr && (cnt_q > CW'(MAXR));
  end
endmodule

// File: rtl/crd_lock.sv
module crd_lock
  import crd_pkg::*;
#(
  parameter int MAXR = MAX_RATIO,
  parameter int CW   = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          meas_stb,
  input  logic [CW-1:0] meas_cnt,
  input  logic          overrun,
  output logic          locked,
  output logic [CW-1:0] ratio
);
  logic          lock_q, lock_d;
  logic          have_q, have_d;
  logic [CW-1:0] prev_q, prev_d;
  logic [CW-1:0] rat_q, rat_d;
  logic          in_range;

  always_comb in_range = (meas_cnt != '0) && (meas_cnt <= CW'(MAXR));

  always_comb begin
    lock_d = lock_q;
    have_d = have_q;
    prev_d = prev_q;
    rat_d  = rat_q;
    if (clr || overrun) begin
      lock_d = 1'b0;
      have_d = 1'b0;
    end else if (meas_stb) begin
      if (!in_range) begin
        lock_d = 1'b0;
        have_d = 1'b0;
      end else begin
        have_d = 1'b1;
        prev_d = meas_cnt;
        if (have_q && meas_cnt == prev_q) begin
          lock_d = 1'b1;
          rat_d  = meas_cnt;
        end else begin
          lock_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      have_q <= 1'b0;
      prev_q <= '0;
      rat_q  <= '0;
    end else begin
      lock_q <= lock_d;
      have_q <= have_d;
      prev_q <= prev_d;
      rat_q  <= rat_d;
    end
  end

  always_comb begin
    locked = lock_q;
    ratio  = rat_q;
  end
endmodule

// File: rtl/clk_ratio_detect.sv
module clk_ratio_detect
  import crd_pkg::*;
#(
  parameter int MAXR = MAX_RATIO,
  parameter int FW   = FIELD_W,
  parameter int CW   = CNT_W
) (
  input  logic          clk_fast,
  input  logic          clk_slow,
  input  logic          rst_n,
  input  logic          detect_en,
  input  logic [FW-1:0] manual_ratio,
  output logic [FW-1:0] ratio_out,
  output logic          ratio_valid
);
  localparam logic [FW-1:0] SAFE = FW'(MAXR - 1);

  logic          rst_m_q, rst_sync_n;
  logic          slow_evt;
  logic          meas_stb;
  logic [CW-1:0] meas_cnt;
  logic          overrun;
  logic          locked;
  logic [CW-1:0] ratio;
  logic          clr;

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_m_q    <= 1'b1;
      rst_sync_n <= rst_m_q;
    end
  end

  always_comb clr = !detect_en;

  crd_edge_sync u_sync (
    .clk_fast   (clk_fast),
    .clk_slow   (clk_slow),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n),
    .slow_evt   (slow_evt)
  );

  crd_period_counter #(.MAXR(MAXR), .CW(CW)) u_cnt (
    .clk      (clk_fast),
    .rst_n    (rst_sync_n),
    .clr      (clr),
    .slow_evt (slow_evt),
    .meas_stb (meas_stb),
    .meas_cnt (meas_cnt),
    .overrun  (overrun)
  );

  crd_lock #(.MAXR(MAXR), .CW(CW)) u_lock (
    .clk      (clk_fast),
    .rst_n    (rst_sync_n),
    .clr      (clr),
    .meas_stb (meas_stb),
    .meas_cnt (meas_cnt),
    .overrun  (overrun),
    .locked   (locked),
    .ratio    (ratio)
  );

  always_comb begin
    ratio_valid = detect_en && locked;
    if (!detect_en)  ratio_out = manual_ratio;
    else if (locked) ratio_out = FW'(ratio - 1'b1);
    else             ratio_out = SAFE;
  end
endmodule

// File: rtl/crd_checker.sv
module crd_checker #(
  parameter int FW = 4,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          detect_en,
  input logic [FW-1:0] manual_ratio,
  input logic [FW-1:0] ratio_out,
  input logic          ratio_valid,
  input logic          meas_stb,
  input logic          overrun
);
  AST_MANUAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !detect_en |-> ratio_out == manual_ratio); // R1
  AST_OFF_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(detect_en) |=> !ratio_valid); // R2
  AST_SAFE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (detect_en && !ratio_valid) |-> ratio_out == FW'(7)); // R3
  AST_WS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_valid |-> ratio_out <= FW'(7)); // R4
  AST_LOCK_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ratio_valid) |-> $past(meas_stb)); // R5
  AST_OVERRUN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> !ratio_valid); // R7
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> !ratio_valid); // R9
endmodule

bind clk_ratio_detect crd_checker #(.FW(FW), .CW(CW)) u_chk (
  .clk          (clk_fast),
  .rst_n        (rst_sync_n),
  .detect_en    (detect_en),
  .manual_ratio (manual_ratio),
  .ratio_out    (ratio_out),
  .ratio_valid  (ratio_valid),
  .meas_stb     (meas_stb),
  .overrun      (overrun)
);

// File: tb/tb_clk_ratio_detect.sv
module tb_clk_ratio_detect;
  logic       clk_fast = 1'b0;
  logic       clk_slow = 1'b0;
  logic       rst_n = 1'b0;
  logic       detect_en = 1'b0;
  logic [3:0] manual_ratio = 4'd0;
  logic [3:0] ratio_out;
  logic       ratio_valid;

  int div = 4;
  int ph  = 0;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  clk_ratio_detect dut (
    .clk_fast     (clk_fast),
    .clk_slow     (clk_slow),
    .rst_n        (rst_n),
    .detect_en    (detect_en),
    .manual_ratio (manual_ratio),
    .ratio_out    (ratio_out),
    .ratio_valid  (ratio_valid)
  );

  // 50 MHz fast clock; slow clock is fast divided by div (0 = stalled)
  always begin
    #10;
    if (div != 0) begin
      if (ph == 0) clk_slow = 1'b1;
      else if (ph == div / 2) clk_slow = 1'b0;
      ph = (ph + 1 >= div) ? 0 : ph + 1;
    end
    clk_fast = 1'b1;
    #10;
    if (div == 1) clk_slow = 1'b0;
    clk_fast = 1'b0;
  end

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_fast);
  endtask

  task automatic t_reset;
    detect_en = 1'b1;
    manual_ratio = 4'd2;
    cyc(3);
    chk("R9 valid in reset", {3'b0, ratio_valid}, 4'd0);
    chk("R3 value in reset", ratio_out, 4'd7);
    rst_n = 1'b1;
    cyc(3);
  endtask

  task automatic t_manual;
    detect_en = 1'b0;
    manual_ratio = 4'd5;
    cyc(2);
    chk("R1 manual 5", ratio_out, 4'd5);
    chk("R2 valid off", {3'b0, ratio_valid}, 4'd0);
    manual_ratio = 4'd13;
    cyc(1);
    chk("R1 manual 13", ratio_out, 4'd13);
  endtask

  task automatic t_first;
    detect_en = 1'b0;
    div = 4;
    cyc(2);
    detect_en = 1'b1;
    cyc(7);
    chk("R5 no early lock", {3'b0, ratio_valid}, 4'd0);
    chk("R3 safe before lock", ratio_out, 4'd7);
    cyc(20);
    chk("R5 locked later", {3'b0, ratio_valid}, 4'd1);
  endtask

  task automatic t_ratio(input int n);
    detect_en = 1'b0;
    div = n;
    manual_ratio = 4'd11;
    cyc(2);
    detect_en = 1'b1;
    cyc(5 * n + 12);
    chk($sformatf("R6 valid ratio %0d", n), {3'b0, ratio_valid}, 4'd1);
    chk($sformatf("R4 ws ratio %0d", n), ratio_out, 4'(n - 1));
  endtask

  task automatic t_change;
    bit saw_low = 0;
    detect_en = 1'b0;
    div = 3;
    cyc(2);
    detect_en = 1'b1;
    cyc(30);
    chk("R8 lock at 3", ratio_out, 4'd2);
    div = 6;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_fast);
      if (!ratio_valid) saw_low = 1;
    end
    chk("R8 valid dropped", {3'b0, saw_low}, 4'd1);
    cyc(30);
    chk("R8 relock valid", {3'b0, ratio_valid}, 4'd1);
    chk("R8 relock value", ratio_out, 4'd5);
  endtask

  task automatic t_slow;
    detect_en = 1'b0;
    div = 9;
    cyc(2);
    detect_en = 1'b1;
    cyc(60);
    chk("R7 ratio 9 not valid", {3'b0, ratio_valid}, 4'd0);
    chk("R7 ratio 9 safe", ratio_out, 4'd7);
    div = 2;
    cyc(20);
    chk("R7 lock at 2", ratio_out, 4'd1);
    div = 0;
    cyc(15);
    chk("R7 stall not valid", {3'b0, ratio_valid}, 4'd0);
    chk("R7 stall safe", ratio_out, 4'd7);
  endtask

  task automatic t_disable;
    div = 1;
    manual_ratio = 4'd9;
    detect_en = 1'b0;
    cyc(2);
    detect_en = 1'b1;
    cyc(10);
    chk("R4 lock 1:1", ratio_out, 4'd0);
    detect_en = 1'b0;
    #1;
    chk("R1 disable passthrough", ratio_out, 4'd9);
    cyc(1);
    chk("R2 valid cleared", {3'b0, ratio_valid}, 4'd0);
    detect_en = 1'b1;
    cyc(1);
    chk("R5 relock needs pair", {3'b0, ratio_valid}, 4'd0);
    cyc(10);
    chk("R6 relock 1:1", {3'b0, ratio_valid}, 4'd1);
  endtask

  initial begin
    cyc(1);
    t_reset();
    t_manual();
    t_first();
    for (int n = 1; n <= 8; n++) t_ratio(n);
    t_change();
    t_slow();
    t_disable();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule